// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Carry

This block moves an operand one bit position per operation. It covers logical shifts, an arithmetic right shift that keeps the sign, plain rotates, and rotates that pass through the carry flag. The data path is 16 bits wide. A width select picks the full word or only its low byte, and the carry flag is written on every operation. For the two through-carry rotates the carry flag is also read, so the rotation covers 9 or 17 bits.

The result and the new carry are registered by default. A sequencing controller can feed `result_o` and `carry_o` back into `data_i` and `carry_i` to build a multi-bit shift, one position per clock. A parameter removes the register for use inside a combinational path.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 3'b010 shifts right logically: a zero enters the top bit of the selected width, every bit moves one place down, and the old bit 0 becomes the carry.
- R2: Operation code 3'b001 shifts left. This one code serves both the logical and the arithmetic left shift. A zero enters bit 0 and the old top bit of the selected width becomes the carry. The incoming carry has no effect.
- R3: Operation code 3'b011 shifts right arithmetically: the old top bit stays in place, the other bits move one place down, and the old bit 0 becomes the carry.
- R4: Operation code 3'b100 rotates left: the old top bit goes both to bit 0 and to the carry.
- R5: Operation code 3'b101 rotates right: the old bit 0 goes both to the top bit and to the carry.
- R6: Operation code 3'b110 rotates left through carry: the old carry enters bit 0 and the old top bit becomes the carry. Repeating it width+1 times restores both operand and carry.
- R7: Operation code 3'b111 rotates right through carry: the old carry enters the top bit and the old bit 0 becomes the carry. Repeating it width+1 times restores both operand and carry.
- R8: With `wide_i` = 0 the operation acts on bits 7..0, bit 7 is the top bit, and bits 15..8 pass through unchanged. With `wide_i` = 1 the operation acts on bits 15..0.
- R9: Operation code 3'b000 passes the operand and the carry through unchanged.
- R10: In the registered variant, results appear on the outputs one clock after the inputs are sampled. While `rst_n` is low, `result_o` and `carry_o` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operand, 0 = low byte only |
| data_i | input | 16 | Operand |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Shifted or rotated value |
| carry_o | output | 1 | New carry flag |

## Verification
Each property compares the outputs with the inputs one clock earlier. The properties therefore assume that the inputs are stable and known at each sampling edge, and that the edge before them was not a reset edge. The properties require `$past(rst_n)` to enforce the second condition. The bench changes `op_i`, `wide_i`, `data_i` and `carry_i` only on falling edges, so every rising edge sees settled values. The bench raises reset away from the clock edges, and each check is sampled on the falling edge after the capturing rising edge. In the feedback loops the bench copies the outputs back into the inputs, which keeps the stimulus inside the same single-step contract.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   typedef enum logic [2:0] {
      OP_PASS = 3'd0,
      OP_SHL  = 3'd1,
      OP_SHR  = 3'd2,
      OP_SAR  = 3'd3,
      OP_ROL  = 3'd4,
      OP_ROR  = 3'd5,
      OP_RCL  = 3'd6,
      OP_RCR  = 3'd7
   } shrot_op_e;

   localparam int unsigned OP_W = 3;
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  shrot_op_e  op,
   input  logic [W-1:0] d,
   input  logic         c,
   output logic [W-1:0] q,
   output logic         co
);
   localparam int unsigned MSB = W - 1;

   if (W < 2) begin : g_bad_w
      $error("shrot_lane: W must be at least 2");
   end

   always_comb begin
      q  = d;
      co = c;
      case (op)
         OP_SHL: begin q = {d[MSB-1:0], 1'b0};   co = d[MSB]; end
         OP_SHR: begin q = {1'b0, d[MSB:1]};     co = d[0];   end
         OP_SAR: begin q = {d[MSB], d[MSB:1]};   co = d[0];   end
         OP_ROL: begin q = {d[MSB-1:0], d[MSB]}; co = d[MSB]; end
         OP_ROR: begin q = {d[0], d[MSB:1]};     co = d[0];   end
         OP_RCL: begin q = {d[MSB-1:0], c};      co = d[MSB]; end
         OP_RCR: begin q = {c, d[MSB:1]};        co = d[0];   end
         default: begin q = d; co = c; end
      endcase
   end
endmodule

// File: rtl/shrot_stage.sv
module shrot_stage #(
   parameter int unsigned W          = 16,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   input  logic         c_in,
   output logic [W-1:0] d_out,
   output logic         c_out
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_out <= '0;
            c_out <= 1'b0;
         end else begin
            d_out <= d_in;
            c_out <= c_in;
         end
      end
   end else begin : g_comb
      assign d_out = d_in;
      assign c_out = c_in;
   end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NARROW_W   = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);
   localparam int unsigned UPPER_W = DATA_W - NARROW_W;

   if (NARROW_W < 2 || NARROW_W >= DATA_W) begin : g_bad_widths
      $error("shrot_unit: NARROW_W must lie in [2, DATA_W)");
   end

   shrot_op_e         op;
   logic [NARROW_W-1:0] nq;
   logic                nc;
   logic [DATA_W-1:0]   wq;
   logic                wc;
   logic [DATA_W-1:0]   sel_q;
   logic                sel_c;

   assign op = shrot_op_e'(op_i);

   shrot_lane #(.W(NARROW_W)) u_lane_narrow (
      .op (op),
      .d  (data_i[NARROW_W-1:0]),
      .c  (carry_i),
      .q  (nq),
      .co (nc)
   );

   shrot_lane #(.W(DATA_W)) u_lane_wide (
      .op (op),
      .d  (data_i),
      .c  (carry_i),
      .q  (wq),
      .co (wc)
   );

   logic [UPPER_W-1:0] upper_keep;
   assign upper_keep = data_i[DATA_W-1:NARROW_W];

   always_comb begin
      if (wide_i) begin
         sel_q = wq;
         sel_c = wc;
      end else begin
         sel_q = {upper_keep, nq};
         sel_c = nc;
      end
   end

   shrot_stage #(.W(DATA_W), .REGISTERED(REGISTERED)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (sel_q),
      .c_in  (sel_c),
      .d_out (result_o),
      .c_out (carry_o)
   );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
   import shrot_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned NARROW_W   = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_i,
   input logic              wide_i,
   input logic [DATA_W-1:0] data_i,
   input logic              carry_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o
);
   if (REGISTERED) begin : g_props
      // R10
      reset_zero_chk: assert property (@(posedge clk)
         !rst_n |-> (result_o == '0 && carry_o == 1'b0));

      // R8
      upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(wide_i)) |->
         result_o[DATA_W-1:NARROW_W] == $past(data_i[DATA_W-1:NARROW_W]));

      // R9
      pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_PASS) |->
         (result_o == $past(data_i) && carry_o == $past(carry_i)));

      // R1
      shr_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_SHR && $past(wide_i)) |->
         (result_o[DATA_W-1] == 1'b0 && carry_o == $past(data_i[0])));

      // R3
      sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_SAR && $past(wide_i)) |->
         result_o[DATA_W-1] == $past(data_i[DATA_W-1]));

      // R4
      rol_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_ROL && $past(wide_i)) |->
         $countones(result_o) == $countones($past(data_i)));

      // R6
      rcl_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_RCL && $past(wide_i)) |->
         $countones({result_o, carry_o}) == $countones({$past(data_i), $past(carry_i)}));

      // R7
      rcr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(op_i) == OP_RCR && $past(wide_i)) |->
         (carry_o == $past(data_i[0]) && result_o[DATA_W-1] == $past(carry_i)));
   end
endmodule

bind shrot_unit shrot_unit_chk #(
   .DATA_W(DATA_W), .NARROW_W(NARROW_W), .REGISTERED(REGISTERED)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i), .data_i(data_i),
   .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 20;

   // {op[37:35], wide[34], cin[33], data[32:17], exp_q[16:1], exp_c[0]}
   localparam logic [37:0] VEC [NVEC] = '{
      {3'd2, 1'b1, 1'b0, 16'h8001, 16'h4000, 1'b1},  // R1 wide
      {3'd2, 1'b0, 1'b0, 16'hAB81, 16'hAB40, 1'b1},  // R1 narrow, R8
      {3'd1, 1'b1, 1'b0, 16'h8001, 16'h0002, 1'b1},  // R2 wide
      {3'd1, 1'b0, 1'b0, 16'h12C3, 16'h1286, 1'b1},  // R2 narrow, R8
      {3'd3, 1'b1, 1'b1, 16'h8002, 16'hC001, 1'b0},  // R3 negative
      {3'd3, 1'b0, 1'b0, 16'hFF81, 16'hFFC0, 1'b1},  // R3 narrow
      {3'd3, 1'b1, 1'b0, 16'h4003, 16'h2001, 1'b1},  // R3 positive
      {3'd4, 1'b1, 1'b0, 16'h8001, 16'h0003, 1'b1},  // R4 wide
      {3'd4, 1'b0, 1'b0, 16'h5580, 16'h5501, 1'b1},  // R4 narrow
      {3'd5, 1'b1, 1'b0, 16'h0001, 16'h8000, 1'b1},  // R5 wide
      {3'd5, 1'b0, 1'b1, 16'h0102, 16'h0101, 1'b0},  // R5 narrow
      {3'd6, 1'b1, 1'b0, 16'h8000, 16'h0000, 1'b1},  // R6 wide
      {3'd6, 1'b1, 1'b1, 16'h0001, 16'h0003, 1'b0},  // R6 carry in
      {3'd6, 1'b0, 1'b1, 16'hAA80, 16'hAA01, 1'b1},  // R6 narrow
      {3'd7, 1'b1, 1'b0, 16'h0001, 16'h0000, 1'b1},  // R7 wide
      {3'd7, 1'b1, 1'b1, 16'h0000, 16'h8000, 1'b0},  // R7 carry in
      {3'd7, 1'b0, 1'b1, 16'h3401, 16'h3480, 1'b1},  // R7 narrow
      {3'd0, 1'b1, 1'b1, 16'hBEEF, 16'hBEEF, 1'b1},  // R9 wide
      {3'd0, 1'b0, 1'b0, 16'h1234, 16'h1234, 1'b0},  // R9 narrow
      {3'd1, 1'b1, 1'b1, 16'h4000, 16'h8000, 1'b0}   // R2 carry ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic        wide_i = 1'b1;
   logic [15:0] data_i = '0;
   logic        carry_i = 1'b0;
   logic [15:0] result_o;
   logic        carry_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shrot_unit u_shrot_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i),
      .data_i(data_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
   );

   function automatic string tag_of(input logic [2:0] op, input logic wide);
      string t;
      case (op)
         3'd1: t = "R2";
         3'd2: t = "R1";
         3'd3: t = "R3";
         3'd4: t = "R4";
         3'd5: t = "R5";
         3'd6: t = "R6";
         3'd7: t = "R7";
         default: t = "R9";
      endcase
      if (!wide) t = {t, "/R8"};
      return t;
   endfunction

   task automatic check(input string tag, input logic [15:0] exp_q, input logic exp_c);
      n_run++;
      if (result_o !== exp_q || carry_o !== exp_c) begin
         n_fail++;
         $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                  tag, result_o, carry_o, exp_q, exp_c);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic w, input logic c, input logic [15:0] d);
      op_i = op; wide_i = w; carry_i = c; data_i = d;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      data_i = 16'hFFFF; carry_i = 1'b1; op_i = 3'd0;
      repeat (3) @(negedge clk);
      check("R10 reset state", 16'h0000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: one-cycle latency of R10 applies to every entry
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][37:35], VEC[i][34], VEC[i][33], VEC[i][32:17]);
         check(tag_of(VEC[i][37:35], VEC[i][34]), VEC[i][16:1], VEC[i][0]);
      end

      // R10 latency: output holds last result until the next edge
      op_i = 3'd4; wide_i = 1'b1; data_i = 16'h0001; carry_i = 1'b0;
      #1;
      check("R10 no change before edge", 16'h8000, 1'b0);
      @(posedge clk); @(negedge clk);
      check("R10 result after edge", 16'h0002, 1'b0);

      // R6: 17 steps of through-carry rotate left restore 16-bit operand
      data_i = 16'h1234; carry_i = 1'b1; op_i = 3'd6; wide_i = 1'b1;
      for (int k = 0; k < 17; k++) begin
         @(posedge clk); @(negedge clk);
         data_i = result_o; carry_i = carry_o;
      end
      check("R6 17-step round trip", 16'h1234, 1'b1);

      // R7: 9 steps of through-carry rotate right on low byte restore it
      data_i = 16'h5AC3; carry_i = 1'b0; op_i = 3'd7; wide_i = 1'b0;
      for (int k = 0; k < 9; k++) begin
         @(posedge clk); @(negedge clk);
         data_i = result_o; carry_i = carry_o;
      end
      check("R7/R8 9-step round trip", 16'h5AC3, 1'b0);

      // R4: 16 plain rotates restore the operand
      data_i = 16'hA5F0; carry_i = 1'b0; op_i = 3'd4; wide_i = 1'b1;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk); @(negedge clk);
         data_i = result_o; carry_i = carry_o;
      end
      check("R4 16-step round trip", 16'hA5F0, 1'b0);

      // R3: repeated arithmetic right shift saturates to all ones
      data_i = 16'h8000; carry_i = 1'b0; op_i = 3'd3; wide_i = 1'b1;
      for (int k = 0; k < 15; k++) begin
         @(posedge clk); @(negedge clk);
         data_i = result_o; carry_i = carry_o;
      end
      check("R3 sign fill", 16'hFFFF, 1'b0);

      // R10: asynchronous reset mid-run clears outputs
      apply(3'd0, 1'b1, 1'b1, 16'hCAFE);
      check("R9 before reset", 16'hCAFE, 1'b1);
      #2 rst_n = 1'b0;
      #1;
      check("R10 async clear", 16'h0000, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R10 watchdog: done=%b expected done=1", done);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule